// File: doc/BRIEF.md
# Quarter-Step Fractional Baud Tick Generator

This block turns the system clock into a one-cycle enable pulse at sixteen times the serial bit rate, which a separate transmitter and receiver use to pace their oversampling. The rate comes from a divider word. A fixed-point field inside that word gives the tick period in quarter clock cycles, above an implied floor of one full cycle. Because the period can include a fraction, the block stretches some tick intervals by one extra clock. It spreads those stretched intervals evenly over each group of four ticks, so the average period is exact and no single gap is off from the ideal by more than one clock.

The divider word is sampled on every clock. The bits below the field carry no meaning. When the field changes, the interval counter and the fraction accumulator start again from the new setting. The pulse is suppressed in the cycle where the change is seen, so a half-finished interval never produces a stray tick. The output is a clock enable for logic that stays on the system clock. It is not a generated clock.

Top module: `qbaud_tick_gen`

## Requirements
- R1: Only the field `div_i[FRAC_LSB+FIELD_W-1:FRAC_LSB]` (default bits 20:6) is used. Changing bits `FRAC_LSB-1:0` (default 5:0) causes no restart and does not change the tick sequence.
- R2: Let the field value be N, let Q = 4 + N quarter clocks, and let I = Q div 4 and F = Q mod 4. Take the restart edge as edge 0. The k-th tick (k >= 1) after a restart is high in the cycle that follows edge k*I + floor((k-1)*F/4) - 1, and the output is low in every other cycle.
- R3: A field value of 0 gives one tick on every clock cycle from the cycle after the restart edge.
- R4: A field value of 32764 (I = 8192, F = 0) gives ticks exactly 8192 clocks apart, which is the slowest rate the default field needs.
- R5: When I > 1, a tick is high for a single cycle and is never high in two adjacent cycles.
- R6: In a cycle where the field differs from its value at the previous clock edge, the tick is low. That edge then acts as a restart edge for R2.
- R7: While `rst_n` is low the tick is low. The first clock edge after reset is released acts as a restart edge.
- R8: Between two ticks with no restart between them, the gap is I or I+1 cycles. When F = 0 the gap is exactly I.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | FRAC_LSB+FIELD_W | Divider word; the quarter-step field sits above bit FRAC_LSB |
| tick_o | output | 1 | One-cycle enable at sixteen times the bit rate |

## Verification
The bound checker evaluates four things on every cycle. It bounds the gap between ticks by the current I and F. It checks that a tick is never stretched when I > 1. It checks the quiet cycle on a field change and during reset. It checks the continuous pulse train at field zero. Those properties hold the spacing only within one clock. The exact position of every stretched interval inside a group of four, and the fact that the low bits have no effect on the sequence, only the bench's scenarios can show. The bench does this by comparing each cycle after a restart against the closed-form tick schedule, for directed fields, the slowest setting and random fields.

// File: rtl/qbaud_pkg.sv
package qbaud_pkg;

   // Width of the integer part of the tick period, in whole clocks.
   function automatic int whole_width(input int field_w, input int frac_bits);
      return field_w + 1 - frac_bits;
   endfunction

   // Width used for the fraction (never zero, so that ports stay legal).
   function automatic int frac_width(input int frac_bits);
      return (frac_bits > 0) ? frac_bits : 1;
   endfunction

endpackage

// File: rtl/qbaud_decode.sv
module qbaud_decode
   import qbaud_pkg::*;
#(
   parameter int FRAC_LSB  = 6,
   parameter int FIELD_W   = 15,
   parameter int FRAC_BITS = 2,
   localparam int DIV_W    = FRAC_LSB + FIELD_W,
   localparam int WHOLE_W  = whole_width(FIELD_W, FRAC_BITS),
   localparam int FRAC_W   = frac_width(FRAC_BITS)
) (
   input  logic [DIV_W-1:0]   div_i,
   output logic [FIELD_W-1:0] field_o,
   output logic [WHOLE_W-1:0] whole_o,
   output logic [FRAC_W-1:0]  frac_o
);

   localparam int Q_W = FIELD_W + 1;

   logic [Q_W-1:0] quarters;

   assign field_o  = div_i[DIV_W-1:FRAC_LSB];
   // Implied offset of one whole clock expressed in fractional units.
   assign quarters = {1'b0, field_o} + Q_W'(1 << FRAC_BITS);
   assign whole_o  = quarters[Q_W-1:FRAC_BITS];

   generate
      if (FRAC_BITS > 0) begin : g_frac
         assign frac_o = quarters[FRAC_W-1:0];
      end else begin : g_nofrac
         assign frac_o = '0;
      end

      if (FRAC_LSB > 0) begin : g_low
         logic unused_low;
         assign unused_low = ^div_i[FRAC_LSB-1:0];
      end
   endgenerate

endmodule

// File: rtl/qbaud_frac_accum.sv
module qbaud_frac_accum
   import qbaud_pkg::*;
#(
   parameter int FRAC_BITS = 2,
   localparam int FRAC_W   = frac_width(FRAC_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              step_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic              stretch_o
);

   generate
      if (FRAC_BITS > 0) begin : g_acc
         logic [FRAC_W-1:0] acc;
         logic [FRAC_W:0]   sum;

         assign sum       = {1'b0, acc} + {1'b0, frac_i};
         assign stretch_o = sum[FRAC_W];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc <= '0;
            end else if (clear_i) begin
               acc <= '0;
            end else if (step_i) begin
               acc <= sum[FRAC_W-1:0];
            end
         end
      end else begin : g_noacc
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ clear_i ^ step_i ^ frac_i[0];
         assign stretch_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/qbaud_counter.sv
module qbaud_counter #(
   parameter int WHOLE_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               step_i,
   input  logic               stretch_i,
   input  logic [WHOLE_W-1:0] whole_i,
   output logic               zero_o
);

   logic [WHOLE_W-1:0] cnt;
   logic [WHOLE_W-1:0] base;

   assign base   = whole_i - WHOLE_W'(1);
   assign zero_o = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load_i) begin
         cnt <= base;
      end else if (step_i) begin
         cnt <= base + WHOLE_W'(stretch_i);
      end else begin
         cnt <= cnt - WHOLE_W'(1);
      end
   end

endmodule

// File: rtl/qbaud_tick_gen.sv
module qbaud_tick_gen
   import qbaud_pkg::*;
#(
   parameter int FRAC_LSB  = 6,
   parameter int FIELD_W   = 15,
   parameter int FRAC_BITS = 2,
   localparam int DIV_W    = FRAC_LSB + FIELD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   localparam int WHOLE_W = whole_width(FIELD_W, FRAC_BITS);
   localparam int FRAC_W  = frac_width(FRAC_BITS);

   generate
      if (FRAC_BITS < 0 || FRAC_BITS > 4) begin : g_bad_frac
         $error("qbaud_tick_gen: FRAC_BITS must lie in 0..4");
      end
      if (FIELD_W <= FRAC_BITS) begin : g_bad_field
         $error("qbaud_tick_gen: FIELD_W must exceed FRAC_BITS");
      end
      if (FRAC_LSB < 0) begin : g_bad_lsb
         $error("qbaud_tick_gen: FRAC_LSB must not be negative");
      end
   endgenerate

   logic [FIELD_W-1:0] field;
   logic [FIELD_W-1:0] field_q;
   logic [WHOLE_W-1:0] whole;
   logic [FRAC_W-1:0]  frac;
   logic               running;
   logic               changed;
   logic               restart;
   logic               zero;
   logic               stretch;

   qbaud_decode #(
      .FRAC_LSB (FRAC_LSB),
      .FIELD_W  (FIELD_W),
      .FRAC_BITS(FRAC_BITS)
   ) u_decode (
      .div_i  (div_i),
      .field_o(field),
      .whole_o(whole),
      .frac_o (frac)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         field_q <= '0;
      end else begin
         running <= 1'b1;
         field_q <= field;
      end
   end

   assign changed = (field != field_q);
   assign restart = !running || changed;
   assign tick_o  = running && zero && !changed;

   qbaud_frac_accum #(
      .FRAC_BITS(FRAC_BITS)
   ) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (restart),
      .step_i   (tick_o),
      .frac_i   (frac),
      .stretch_o(stretch)
   );

   qbaud_counter #(
      .WHOLE_W(WHOLE_W)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (restart),
      .step_i   (tick_o),
      .stretch_i(stretch),
      .whole_i  (whole),
      .zero_o   (zero)
   );

endmodule

// File: rtl/qbaud_tick_gen_chk.sv
module qbaud_tick_gen_chk
   import qbaud_pkg::*;
#(
   parameter int FRAC_LSB  = 6,
   parameter int FIELD_W   = 15,
   parameter int FRAC_BITS = 2,
   localparam int DIV_W    = FRAC_LSB + FIELD_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] div_i,
   input logic             tick_o
);

   localparam int WHOLE_W = whole_width(FIELD_W, FRAC_BITS);
   localparam int GAP_W   = WHOLE_W + 1;

   logic [FIELD_W-1:0] fld;
   logic [FIELD_W-1:0] fld_q;
   logic [GAP_W-1:0]   gap;
   logic [GAP_W-1:0]   ideal;
   logic               has_frac;
   logic               armed;
   logic               renew;

   assign fld      = div_i[DIV_W-1:FRAC_LSB];
   assign ideal    = GAP_W'((int'(fld) + (1 << FRAC_BITS)) >> FRAC_BITS);
   assign has_frac = ((int'(fld) % (1 << FRAC_BITS)) != 0);
   assign renew    = !armed || (fld != fld_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         fld_q <= '0;
         gap   <= '0;
      end else begin
         armed <= 1'b1;
         fld_q <= fld;
         if (renew || tick_o) begin
            gap <= GAP_W'(1);
         end else begin
            gap <= gap + GAP_W'(1);
         end
      end
   end

   // R7: quiet while reset is held
   assert_reset_quiet_R7: assert property (@(posedge clk) !rst_n |-> !tick_o);

   // R7: the first edge after reset release is a restart
   assert_first_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !tick_o);

   // R6: no pulse in the cycle a new field is presented
   assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && fld != fld_q) |-> !tick_o);

   // R5: single-cycle pulse when the interval is longer than one clock
   assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && ideal > GAP_W'(1)) |=> !tick_o);

   // R3: field zero gives a pulse on every cycle once settled
   assert_fastest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!renew && fld == '0) |-> tick_o);

   // R8: gap between ticks is I, or I+1 only if a fraction is present
   assert_gap_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && !renew) |->
         (gap == ideal || (has_frac && gap == ideal + GAP_W'(1))));

   // R8: no gap ever runs past I+1
   assert_gap_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !renew) |-> (gap <= ideal + GAP_W'(1)));

endmodule

bind qbaud_tick_gen qbaud_tick_gen_chk #(
   .FRAC_LSB (FRAC_LSB),
   .FIELD_W  (FIELD_W),
   .FRAC_BITS(FRAC_BITS)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .div_i (div_i),
   .tick_o(tick_o)
);

// File: tb/qbaud_tick_gen_tb.sv
module qbaud_tick_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int FRAC_LSB   = 6;
   localparam int FIELD_W    = 15;
   localparam int DIV_W      = FRAC_LSB + FIELD_W;

   logic             clk   = 1'b0;
   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] div_i = '0;
   logic             tick_o;

   int n_checks = 0;
   int n_errs   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qbaud_tick_gen u_dut (
      .clk   (clk),
      .rst_n (rst_n),
      .div_i (div_i),
      .tick_o(tick_o)
   );

   task automatic check(input logic got, input logic exp, input string req, input int step);
      n_checks++;
      if (got !== exp) begin
         n_errs++;
         $display("FAIL %s step %0d: tick=%0b expected %0b", req, step, got, exp);
      end
   endtask

   // Closed-form schedule: tick k is visible after edge k*I + floor((k-1)*F/4) - 1.
   function automatic logic exp_tick(input int e, input int whole, input int frac);
      for (int k = 1; k <= e + 2; k++) begin
         int t;
         t = k * whole + ((k - 1) * frac) / 4 - 1;
         if (t == e) return 1'b1;
         if (t > e) return 1'b0;
      end
      return 1'b0;
   endfunction

   // Follows the edges after a restart edge and compares every cycle.
   task automatic run_window(input int fld, input int win, input string req,
                             input int mid, input int newlow);
      int   whole;
      int   frac;
      logic prev;
      whole = (4 + fld) / 4;
      frac  = (4 + fld) % 4;
      prev  = 1'b0;
      for (int e = 0; e < win; e++) begin
         @(posedge clk);
         @(negedge clk);
         check(tick_o, exp_tick(e, whole, frac), req, e);
         if (whole > 1) check(prev && tick_o, 1'b0, "R5", e);
         prev = tick_o;
         if (e == mid) div_i[FRAC_LSB-1:0] = 6'(newlow);
      end
   endtask

   task automatic restart_to(input int fld, input int low, input int win, input string req,
                             input int mid, input int newlow);
      @(negedge clk);
      div_i = {15'(fld), 6'(low)};
      #1;
      check(tick_o, 1'b0, "R6", -1);
      run_window(fld, win, req, mid, newlow);
   endtask

   initial begin : main
      int prev_f;
      int f;
      void'($urandom(32'd4711));

      // R7: reset holds the output low
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(tick_o, 1'b0, "R7", i);
      end
      @(negedge clk);
      rst_n = 1'b1;
      // R7 then R3: first edge restarts, field zero ticks every cycle
      run_window(0, 30, "R3", -1, 0);

      // R2: every fraction value and a few wholes
      restart_to(1, 5, 40, "R2", -1, 0);
      restart_to(2, 9, 40, "R2", -1, 0);
      restart_to(3, 0, 40, "R2", -1, 0);
      restart_to(6, 33, 60, "R2", -1, 0);
      restart_to(13, 2, 80, "R2", -1, 0);

      // R1: low bits changed mid-stream, schedule must carry on
      restart_to(5, 0, 60, "R1", 17, 63);
      restart_to(9, 21, 60, "R1", 3, 40);

      // R4: slowest default rate
      restart_to(32764, 7, 16400, "R4", -1, 0);

      // R3: back to the fastest rate
      restart_to(0, 12, 20, "R3", -1, 0);

      // R2 / R6: random fields, each one a restart
      prev_f = 0;
      for (int r = 0; r < 25; r++) begin
         f = int'($urandom_range(0, 47));
         if (f == prev_f) f = f + 1;
         restart_to(f, int'($urandom_range(0, 63)), 70, "R2", -1, 0);
         prev_f = f;
      end

      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule